// File: doc/BRIEF.md
# Receive Descriptor Status Writer

This block is the receive-side descriptor engine of a chained-descriptor Ethernet DMA. The descriptor ring sits in a small internal word memory. Each descriptor is four 32-bit words at a word address that is a multiple of four. Word 0 carries ownership and completion status. Word 1 carries a chain flag and the receive buffer size. Word 3 carries the word address of the next descriptor. Each incoming frame is presented as a byte count, which includes the 4-byte CRC, plus an error flag. Payload movement is not modelled.

For each accepted frame the engine steps through a small state machine. From `ST_IDLE` it moves to `ST_OWN_CHK` when a frame is accepted. `ST_OWN_CHK` reads word 0. If the ownership bit is clear, the frame is dropped and the engine returns to `ST_IDLE` without moving its pointer. If the bit is set, the engine goes to `ST_CFG_RD`, which latches the chain flag and buffer size. It then goes to `ST_LINK_RD`, which latches the next-descriptor link. Last comes `ST_STAT_WR`, which writes the completion status into word 0, advances the pointer and returns to `ST_IDLE`.

A host-side port reads and writes any memory word. Software uses it to build the ring and to hand descriptors back to the engine by writing word 0 as just the ownership bit.

Top module: `rxd_writeback`

## Requirements
- R1: After reset `frm_ready` is 1, `missed_cnt` is 0, and neither `wb_done` nor `frm_dropped` is asserted. The descriptor pointer starts at word address 0.
- R2: A frame that finds bit 31 of the current descriptor's word 0 at 0 is dropped. `frm_dropped` pulses, nothing is written, and the pointer stays put, so the next frame tries the same descriptor again.
- R3: A completed frame writes word 0 with bit 31 = 0, bits 29:16 = length, bit 15 = error summary, bits 9 and 8 = 1, and every other bit 0. Words 1 to 3 are left unchanged.
- R4: When `frm_len` is at most the buffer size in word 1 bits 10:0, the length field equals `frm_len`, with the CRC bytes included.
- R5: `frm_err` = 1 sets bit 15 of the written status.
- R6: When `frm_len` exceeds the buffer size, the length field is the buffer size and bit 15 is set. A length equal to the buffer size is not truncated.
- R7: When word 1 bit 24 is 1, the next descriptor is word 3 bits 5:2 times four. The low two bits and the upper bits of word 3 are ignored.
- R8: When word 1 bit 24 is 0, the next descriptor is the one four words higher, wrapping at the end of memory.
- R9: A link back to address 0 closes the ring, and the engine revisits the first descriptor.
- R10: `missed_cnt` rises by one per dropped frame and saturates at its all-ones value.
- R11: `frm_ready` is low from the cycle after a frame is accepted until the frame is finished. `frm_valid` seen during that time is ignored and produces no completion and no drop.
- R12: A host write stores a word, and a host read returns it on `host_rdata` one cycle later.
- R13: On completion `wb_done` pulses for one cycle, with `wb_addr` giving the descriptor's word address and `wb_word` the status written. `wb_done` and `frm_dropped` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | Frame offered |
| frm_len | input | LEN_W | Frame byte count including CRC |
| frm_err | input | 1 | Frame had a receive error |
| frm_ready | output | 1 | Engine idle, frame accepted when valid |
| wb_done | output | 1 | Status written pulse |
| wb_addr | output | ADDR_W | Word address of completed descriptor |
| wb_word | output | 32 | Status word written |
| frm_dropped | output | 1 | Frame dropped pulse |
| missed_cnt | output | MISS_W | Saturating dropped-frame count |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_addr | input | ADDR_W | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after the strobe |

## Verification
The bench builds a ring whose links skip descriptors and whose link word carries junk low bits. A design that simply incremented the pointer, or used the raw link, would complete at the wrong `wb_addr`. One descriptor has the chain flag clear, which exposes a design that always follows word 3. A frame equal to the buffer size and another larger than it separate an off-by-one compare from a missing truncation.

Frames hitting a descriptor owned by software must not move the pointer. A design that advanced anyway would complete the reclaimed frame at the wrong address. Enough drops are sent to push the narrow bench counter past its maximum, which catches a wrapping counter. `frm_valid` is held high while the engine is busy to catch a second, phantom completion.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWN_CHK,
        ST_CFG_RD,
        ST_LINK_RD,
        ST_STAT_WR
    } rxd_state_e;

    // status word (word 0) field positions
    localparam int OWN_POS   = 31;
    localparam int LEN_POS   = 16;
    localparam int ERR_POS   = 15;
    localparam int FIRST_POS = 9;
    localparam int LAST_POS  = 8;

    // config word (word 1) field position
    localparam int CHAIN_POS = 24;

    // word offsets inside a descriptor
    localparam logic [1:0] OFS_STAT = 2'd0;
    localparam logic [1:0] OFS_CFG  = 2'd1;
    localparam logic [1:0] OFS_LINK = 2'd3;

endpackage

// File: rtl/rxd_ring_mem.sv
module rxd_ring_mem #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic              eng_we,
    input  logic [31:0]       eng_wdata,
    output logic [31:0]       eng_rdata,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [31:0] words [DEPTH];
    logic        host_wr;

    // engine write wins over a host write to the same word in the same cycle
    assign host_wr = host_en && host_we && !(eng_we && eng_addr == host_addr);

    always_ff @(posedge clk) begin
        if (eng_we) begin
            words[eng_addr] <= eng_wdata;
        end
        if (host_wr) begin
            words[host_addr] <= host_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (host_en && !host_we) begin
            host_rdata <= words[host_addr];
        end
    end

    assign eng_rdata = words[eng_addr];

endmodule

// File: rtl/rxd_stat_fmt.sv
module rxd_stat_fmt
    import rxd_pkg::*;
#(
    parameter int LEN_W = 14,
    parameter int BSZ_W = 11
) (
    input  logic [LEN_W-1:0] frame_len,
    input  logic             frame_err,
    input  logic [BSZ_W-1:0] buf_size,
    output logic [31:0]      stat_word
);
    localparam int PAD_W = LEN_W - BSZ_W;

    logic [LEN_W-1:0] size_ext;
    logic             over;
    logic [LEN_W-1:0] kept_len;

    assign size_ext = {{PAD_W{1'b0}}, buf_size};
    assign over     = frame_len > size_ext;
    assign kept_len = over ? size_ext : frame_len;

    always_comb begin
        stat_word                     = '0;
        stat_word[LEN_POS +: LEN_W]   = kept_len;
        stat_word[ERR_POS]            = frame_err | over;
        stat_word[FIRST_POS]          = 1'b1;
        stat_word[LAST_POS]           = 1'b1;
        stat_word[OWN_POS]            = 1'b0;
    end

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 14,
    parameter int BSZ_W  = 11,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    output logic              frm_ready,
    input  logic [31:0]       rd_data,
    input  logic [31:0]       stat_word,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_we,
    output logic [LEN_W-1:0]  len_q,
    output logic              err_q,
    output logic [BSZ_W-1:0]  size_q,
    output logic              wb_done,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_word,
    output logic              frm_dropped,
    output logic [MISS_W-1:0] missed
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    rxd_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] link_q;
    logic             chain_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and memory port steering
    always_comb begin
        state_d  = state_q;
        eng_addr = {idx_q, OFS_STAT};
        eng_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (frm_valid) begin
                    state_d = ST_OWN_CHK;
                end
            end
            ST_OWN_CHK: begin
                eng_addr = {idx_q, OFS_STAT};
                state_d  = rd_data[OWN_POS] ? ST_CFG_RD : ST_IDLE;
            end
            ST_CFG_RD: begin
                eng_addr = {idx_q, OFS_CFG};
                state_d  = ST_LINK_RD;
            end
            ST_LINK_RD: begin
                eng_addr = {idx_q, OFS_LINK};
                state_d  = ST_STAT_WR;
            end
            ST_STAT_WR: begin
                eng_addr = {idx_q, OFS_STAT};
                eng_we   = 1'b1;
                state_d  = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    assign frm_ready = (state_q == ST_IDLE);

    // outputs and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            link_q      <= '0;
            chain_q     <= 1'b0;
            len_q       <= '0;
            err_q       <= 1'b0;
            size_q      <= '0;
            wb_done     <= 1'b0;
            wb_addr     <= '0;
            wb_word     <= '0;
            frm_dropped <= 1'b0;
            missed      <= '0;
        end else begin
            wb_done     <= 1'b0;
            frm_dropped <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (frm_valid) begin
                        len_q <= frm_len;
                        err_q <= frm_err;
                    end
                end
                ST_OWN_CHK: begin
                    if (!rd_data[OWN_POS]) begin
                        frm_dropped <= 1'b1;
                        if (missed != MISS_MAX) begin
                            missed <= missed + 1'b1;
                        end
                    end
                end
                ST_CFG_RD: begin
                    size_q  <= rd_data[BSZ_W-1:0];
                    chain_q <= rd_data[CHAIN_POS];
                end
                ST_LINK_RD: begin
                    link_q <= rd_data[ADDR_W-1:2];
                end
                ST_STAT_WR: begin
                    wb_done <= 1'b1;
                    wb_addr <= {idx_q, 2'b00};
                    wb_word <= stat_word;
                    idx_q   <= chain_q ? link_q : idx_q + 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_ready) |=> !frm_ready);

    a_r3_done_format: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |-> (!wb_word[OWN_POS] && wb_word[FIRST_POS] && wb_word[LAST_POS]));

    a_r6_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we |-> (stat_word[LEN_POS +: LEN_W] <= {{(LEN_W-BSZ_W){1'b0}}, size_q}));

    a_r2_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_dropped && $past(missed) != MISS_MAX) |-> (missed == $past(missed) + 1'b1));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (missed == MISS_MAX) |=> (missed == MISS_MAX));

    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_done && frm_dropped));

endmodule

// File: rtl/rxd_writeback.sv
module rxd_writeback
    import rxd_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 14,
    parameter int BSZ_W  = 11,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              frm_err,
    output logic              frm_ready,
    output logic              wb_done,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [31:0]       wb_word,
    output logic              frm_dropped,
    output logic [MISS_W-1:0] missed_cnt,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata
);
    logic [ADDR_W-1:0] eng_addr;
    logic              eng_we;
    logic [31:0]       eng_rdata;
    logic [31:0]       stat_word;
    logic [LEN_W-1:0]  len_q;
    logic              err_q;
    logic [BSZ_W-1:0]  size_q;

    rxd_ring_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk        (clk),
        .eng_addr   (eng_addr),
        .eng_we     (eng_we),
        .eng_wdata  (stat_word),
        .eng_rdata  (eng_rdata),
        .host_en    (host_en),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    rxd_stat_fmt #(.LEN_W(LEN_W), .BSZ_W(BSZ_W)) u_fmt (
        .frame_len (len_q),
        .frame_err (err_q),
        .buf_size  (size_q),
        .stat_word (stat_word)
    );

    rxd_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .BSZ_W  (BSZ_W),
        .MISS_W (MISS_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frm_valid   (frm_valid),
        .frm_len     (frm_len),
        .frm_err     (frm_err),
        .frm_ready   (frm_ready),
        .rd_data     (eng_rdata),
        .stat_word   (stat_word),
        .eng_addr    (eng_addr),
        .eng_we      (eng_we),
        .len_q       (len_q),
        .err_q       (err_q),
        .size_q      (size_q),
        .wb_done     (wb_done),
        .wb_addr     (wb_addr),
        .wb_word     (wb_word),
        .frm_dropped (frm_dropped),
        .missed      (missed_cnt)
    );

endmodule

// File: tb/rxd_writeback_tb.sv
`timescale 1ns/1ps
module rxd_writeback_tb;
    localparam int ADDR_W = 6;
    localparam int LEN_W  = 14;
    localparam int BSZ_W  = 11;
    localparam int MISS_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frm_valid = 1'b0;
    logic [LEN_W-1:0]  frm_len = '0;
    logic              frm_err = 1'b0;
    logic              frm_ready;
    logic              wb_done;
    logic [ADDR_W-1:0] wb_addr;
    logic [31:0]       wb_word;
    logic              frm_dropped;
    logic [MISS_W-1:0] missed_cnt;
    logic              host_en = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;

    always #4 clk = ~clk;

    rxd_writeback #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BSZ_W(BSZ_W), .MISS_W(MISS_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
        .frm_err(frm_err), .frm_ready(frm_ready), .wb_done(wb_done),
        .wb_addr(wb_addr), .wb_word(wb_word), .frm_dropped(frm_dropped),
        .missed_cnt(missed_cnt), .host_en(host_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // scoreboard entry: {is_done, addr, word}
    logic [ADDR_W+32:0] exp_q[$];

    // bench model of the ring
    bit        own_m  [16];
    bit        chain_m[16];
    int        size_m [16];
    int        link_m [16];
    int        ptr_m = 0;
    int        miss_m = 0;
    logic [31:0] first_stat;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_stat(input int len, input bit err, input int size);
        logic [31:0] w;
        int kept;
        bit big;
        big  = len > size;
        kept = big ? size : len;
        w = 32'h0000_0300;
        w[29:16] = kept[13:0];
        w[15] = err | big;
        return w;
    endfunction

    task automatic host_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = addr[ADDR_W-1:0]; host_wdata = data;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = addr[ADDR_W-1:0];
        @(negedge clk);
        host_en = 1'b0;
        data = host_rdata;
    endtask

    task automatic build_desc(input int idx, input bit own, input bit chain, input int size, input int link_word);
        logic [31:0] cfg;
        own_m[idx] = own; chain_m[idx] = chain; size_m[idx] = size;
        link_m[idx] = (link_word >> 2) & 15;
        cfg = 32'(size);
        cfg[24] = chain;
        host_write(idx*4,     own ? 32'h8000_0000 : 32'h0);
        host_write(idx*4 + 1, cfg);
        host_write(idx*4 + 3, 32'(link_word));
    endtask

    task automatic reclaim(input int idx);
        own_m[idx] = 1'b1;
        host_write(idx*4, 32'h8000_0000);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, "R13 completion seen", 64'(exp_q.size()), 64'd0);
        @(negedge clk);
    endtask

    // driver: predicts outcome, pushes it, offers the frame for `hold` cycles
    task automatic send_frame(input int len, input bit err, input int hold);
        logic [31:0] w;
        @(negedge clk);
        if (own_m[ptr_m]) begin
            w = mk_stat(len, err, size_m[ptr_m]);
            exp_q.push_back({1'b1, 6'(ptr_m*4), w});
            own_m[ptr_m] = 1'b0;
            ptr_m = chain_m[ptr_m] ? link_m[ptr_m] : (ptr_m + 1) % 16;
        end else begin
            exp_q.push_back({1'b0, 6'd0, 32'd0});
            if (miss_m < 7) miss_m++;
        end
        frm_valid = 1'b1; frm_len = len[LEN_W-1:0]; frm_err = err;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            frm_len = LEN_W'(len + 7 * (i + 1));
        end
        frm_valid = 1'b0;
        wait_drain();
        check(missed_cnt == MISS_W'(miss_m), "R10 missed count", 64'(missed_cnt), 64'(miss_m));
    endtask

    // monitor
    initial begin
        logic [ADDR_W+32:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && (wb_done || frm_dropped)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected event", {wb_done, frm_dropped}, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    if (e[ADDR_W+32]) begin
                        check(wb_done && !frm_dropped, "R13 done pulse", {wb_done, frm_dropped}, 64'b10);
                        check(wb_addr == e[ADDR_W+31:32], "R7 R8 R9 descriptor address", 64'(wb_addr), 64'(e[ADDR_W+31:32]));
                        check(wb_word == e[31:0], "R3 R4 R5 R6 status word", 64'(wb_word), 64'(e[31:0]));
                    end else begin
                        check(frm_dropped && !wb_done, "R2 drop pulse", {wb_done, frm_dropped}, 64'b01);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(frm_ready == 1'b1, "R1 ready after reset", 64'(frm_ready), 64'd1);
        check(missed_cnt == '0, "R1 missed after reset", 64'(missed_cnt), 64'd0);
        check(!wb_done && !frm_dropped, "R1 no pulses after reset", {wb_done, frm_dropped}, 64'd0);

        // ring: 0 -> 2 (link has junk low bits) -> 5 -> (no chain) 6 -> 0
        build_desc(0, 1, 1, 1536, 32'hFFFF_FF0A & 32'h0000_F00A);
        build_desc(2, 1, 1, 1536, 20);
        build_desc(5, 1, 0, 1536, 44);
        build_desc(6, 1, 1, 100,  0);

        send_frame(64, 0, 1);     // R4 R7 at desc 0
        send_frame(1536, 1, 1);   // R5 R6 boundary at desc 2
        send_frame(60, 0, 1);     // R8 chain clear at desc 5
        send_frame(200, 0, 1);    // R6 truncation at desc 6, R9 wraps to 0
        send_frame(80, 0, 1);     // R2 desc 0 not owned -> drop

        // R3: status landed, config word untouched
        host_read(0, first_stat);
        check(first_stat == mk_stat(64, 0, 1536), "R3 word0 readback", 64'(first_stat), 64'(mk_stat(64, 0, 1536)));
        host_read(1, rd);
        check(rd == 32'h0100_0600, "R3 word1 unchanged", 64'(rd), 64'h0100_0600);

        reclaim(0);
        send_frame(90, 1, 1);     // R2 pointer held, completes at 0

        // R10: desc 2 now not owned, push counter to saturation
        for (int k = 0; k < 7; k++) send_frame(70, 0, 1);
        check(missed_cnt == 3'd7, "R10 saturated", 64'(missed_cnt), 64'd7);

        // R11: valid held while busy -> single completion
        reclaim(2);
        send_frame(300, 0, 3);
        check(frm_ready == 1'b1, "R11 idle again", 64'(frm_ready), 64'd1);

        // R12: host port
        host_write(50, 32'hA5C3_5A3C);
        host_read(50, rd);
        check(rd == 32'hA5C3_5A3C, "R12 host readback", 64'(rd), 64'hA5C3_5A3C);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule